// File: doc/BRIEF.md
# Three-Phase Band Current Controller

This block closes the current loop of a three-leg shunt compensating inverter with a bang-bang rule and no carrier. For each phase it forms the target compensation current as the sensed source current minus the computed active (fundamental) current. It then subtracts the sensed inverter current from that target. The result is compared against a programmable band of half-width `band_i`.

When the error leaves the band on the positive side, the leg switches to upper-on. When it leaves on the negative side, the leg switches to lower-on. Inside the band the last state is kept, so the current ramps back and forth within the band. The switching rate follows the load and the band, near 10 kHz for a 50 Hz fundamental.

Each leg drives a complementary pair of gates. A programmable dead gap holds both gates of a leg low before the new gate of that leg turns on. A global enable drops all six gates at once. Samples arrive with a single-cycle `valid_i` strobe, and the comparison is evaluated only on those samples.

Top module: `band_gate_ctrl`

## Requirements
- R1: The target for each phase is `src_i - act_i`, computed on signed two's-complement values with one extra bit, so no input pair can wrap. For example, 32767 - (-32768) gives +65535.
- R2: When a sampled error `target - inv_i` is greater than `band_i`, that leg takes the upper-on state: its `gate_hi_o` bit is 1 and its `gate_lo_o` bit is 0.
- R3: When a sampled error is less than `-band_i`, that leg takes the lower-on state: its `gate_hi_o` bit is 0 and its `gate_lo_o` bit is 1.
- R4: When a sampled error lies within `-band_i..+band_i`, the endpoints included, the leg keeps its previous state.
- R5: The legs are independent. Bit 0 of every vector is phase a, bit 1 is phase b and bit 2 is phase c, and each leg's state depends only on that phase's inputs.
- R6: The upper and lower gates of one leg are never high together.
- R7: After a state change, both gates of the leg stay low for exactly `dead_i + 1` clock cycles before the new gate turns on. A value of 0 gives a one-cycle gap.
- R8: From reset, all six gates stay low until the first valid sample. Every leg starts from the lower-on state, so a first sample inside the band turns on the lower gates.
- R9: While `en_i` is low, all six gates are low in the same cycle, with no clock edge needed. Samples are still evaluated. Once `en_i` returns, the gates follow the current leg states after the dead gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global gate enable; low forces all gates off |
| valid_i | input | 1 | One-cycle strobe marking a new sample |
| src_i | input | 3x16 | Sensed source current per phase, signed |
| act_i | input | 3x16 | Computed active current per phase, signed |
| inv_i | input | 3x16 | Sensed inverter current per phase, signed |
| band_i | input | 15 | Band half-width, unsigned |
| dead_i | input | 8 | Dead gap in clock cycles |
| gate_hi_o | output | 3 | Upper switch gate per leg |
| gate_lo_o | output | 3 | Lower switch gate per leg |

## Verification
The dead-gap assertion compares the low run that ends when a gate rises against the live `dead_i`. It therefore assumes `dead_i` does not change while a leg is between switching off and switching back on. The stimulus changes `dead_i` and `band_i` only after every leg has settled. `valid_i` is taken to be a single-cycle pulse, and `en_i` is taken to move away from clock edges. The bench drives every input at the falling edge and leaves a full settling interval after each sample before the next one.

// File: rtl/hcc_pkg.sv
package hcc_pkg;
  localparam int unsigned NUM_LEGS = 3;

  typedef enum logic {
    LEG_LO = 1'b0,
    LEG_HI = 1'b1
  } leg_e;
endpackage

// File: rtl/hcc_ref_sub.sv
module hcc_ref_sub #(
  parameter  int unsigned IW = 16,
  localparam int unsigned RW = IW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [IW-1:0]        src_i,
  input  logic [IW-1:0]        act_i,
  input  logic [IW-1:0]        inv_i,
  output logic signed [RW-1:0] ref_o,
  output logic signed [IW-1:0] inv_o
);
  logic signed [RW-1:0] src_x, act_x;

  // sign-extend by one bit so the difference cannot wrap
  assign src_x = $signed({src_i[IW-1], src_i});
  assign act_x = $signed({act_i[IW-1], act_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_o <= '0;
      inv_o <= '0;
    end else if (valid_i) begin
      ref_o <= src_x - act_x;
      inv_o <= $signed(inv_i);
    end
  end
endmodule

// File: rtl/hcc_band_leg.sv
module hcc_band_leg import hcc_pkg::*; #(
  parameter  int unsigned IW = 16,
  parameter  int unsigned BW = 15,
  localparam int unsigned RW = IW + 1,
  localparam int unsigned EW = IW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic signed [RW-1:0] ref_i,
  input  logic signed [IW-1:0] inv_i,
  input  logic [BW-1:0]        band_i,
  output leg_e                 state_o
);
  logic signed [EW-1:0] err, band_s;
  logic                 up, dn;
  leg_e                 state_q;

  assign err    = $signed({ref_i[RW-1], ref_i}) - $signed({{2{inv_i[IW-1]}}, inv_i});
  assign band_s = $signed({{(EW-BW){1'b0}}, band_i});
  assign up     = err > band_s;
  assign dn     = err < -band_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        state_q <= LEG_LO;
    else if (vld_i) begin
      if (up)           state_q <= LEG_HI;
      else if (dn)      state_q <= LEG_LO;
    end
  end

  assign state_o = state_q;

  // R4
  band_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && (err <= band_s) && (err >= -band_s)) |=> $stable(state_q));
  // R2
  band_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && (err > band_s)) |=> (state_q == LEG_HI));
  // R3
  band_lower_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && (err < -band_s)) |=> (state_q == LEG_LO));
endmodule

// File: rtl/hcc_dead_leg.sv
module hcc_dead_leg import hcc_pkg::*; #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          active_i,
  input  leg_e          cmd_i,
  input  logic [DW-1:0] dead_i,
  output logic          gate_hi_o,
  output logic          gate_lo_o
);
  logic          on_q;
  leg_e          cur_q;
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b0;
      cur_q <= LEG_LO;
      cnt_q <= '0;
    end else if (!active_i || !en_i) begin
      on_q  <= 1'b0;
      cnt_q <= dead_i;
    end else if (on_q) begin
      if (cmd_i != cur_q) begin
        on_q  <= 1'b0;
        cnt_q <= dead_i;
      end
    end else if (cnt_q == '0) begin
      on_q  <= 1'b1;
      cur_q <= cmd_i;  // latest command wins if it moved during the gap
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // enable gates combinationally so a drop takes effect without an edge
  assign gate_hi_o = en_i & on_q & (cur_q == LEG_HI);
  assign gate_lo_o = en_i & on_q & (cur_q == LEG_LO);

  // checker: consecutive cycles with both gates low, saturating
  logic [DW:0] off_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       off_run <= '0;
    else if (gate_hi_o || gate_lo_o)   off_run <= '0;
    else if (!(&off_run))              off_run <= off_run + 1'b1;
  end

  // R7
  dead_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(gate_hi_o) || $rose(gate_lo_o)) |-> (off_run > {1'b0, dead_i}));
  // R6
  no_shoot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_hi_o && gate_lo_o));
endmodule

// File: rtl/band_gate_ctrl.sv
module band_gate_ctrl import hcc_pkg::*; #(
  parameter int unsigned IW = 16,
  parameter int unsigned BW = 15,
  parameter int unsigned DW = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic                          valid_i,
  input  logic [NUM_LEGS-1:0][IW-1:0]   src_i,
  input  logic [NUM_LEGS-1:0][IW-1:0]   act_i,
  input  logic [NUM_LEGS-1:0][IW-1:0]   inv_i,
  input  logic [BW-1:0]                 band_i,
  input  logic [DW-1:0]                 dead_i,
  output logic [NUM_LEGS-1:0]           gate_hi_o,
  output logic [NUM_LEGS-1:0]           gate_lo_o
);
  localparam int unsigned RW = IW + 1;

  logic vld_q, started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q     <= 1'b0;
      started_q <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (vld_q) started_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    logic signed [RW-1:0] ref_w;
    logic signed [IW-1:0] inv_w;
    leg_e                 state_w;

    hcc_ref_sub #(.IW(IW)) u_ref (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .src_i   (src_i[g]),
      .act_i   (act_i[g]),
      .inv_i   (inv_i[g]),
      .ref_o   (ref_w),
      .inv_o   (inv_w)
    );

    hcc_band_leg #(.IW(IW), .BW(BW)) u_band (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .vld_i   (vld_q),
      .ref_i   (ref_w),
      .inv_i   (inv_w),
      .band_i  (band_i),
      .state_o (state_w)
    );

    hcc_dead_leg #(.DW(DW)) u_dead (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .active_i  (started_q),
      .cmd_i     (state_w),
      .dead_i    (dead_i),
      .gate_hi_o (gate_hi_o[g]),
      .gate_lo_o (gate_lo_o[g])
    );
  end

  // R8
  startup_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> ((gate_hi_o == '0) && (gate_lo_o == '0)));
  // R9
  enable_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> ((gate_hi_o == '0) && (gate_lo_o == '0)));
endmodule

// File: tb/band_gate_ctrl_tb_top.sv
module band_gate_ctrl_tb_top;
  localparam int IW = 16;
  localparam int BW = 15;
  localparam int DW = 8;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                en = 1'b1;
  logic                valid = 1'b0;
  logic [2:0][IW-1:0]  src = '0, act = '0, inv = '0;
  logic [BW-1:0]       band = 15'd100;
  logic [DW-1:0]       dead = 8'd3;
  logic [2:0]          ghi, glo;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int overlap_seen = 0;
  logic [2:0] st = 3'b000;   // model leg states, 1 = upper-on

  int          due_q[$];
  logic [5:0]  exp_q[$];
  string       req_q[$];

  always #5 clk = ~clk;

  band_gate_ctrl #(.IW(IW), .BW(BW), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .valid_i(valid),
    .src_i(src), .act_i(act), .inv_i(inv),
    .band_i(band), .dead_i(dead),
    .gate_hi_o(ghi), .gate_lo_o(glo)
  );

  task automatic chk(string req, logic [5:0] actv, logic [5:0] expv);
    checks++;
    if (actv !== expv) begin
      errors++;
      $display("FAIL %s: gates hi/lo actual %b expected %b", req, actv, expv);
    end
  endtask

  task automatic chk_int(string req, int actv, int expv);
    checks++;
    if (actv != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actv, expv);
    end
  endtask

  // monitor: compares scoreboard entries when due
  always @(negedge clk) begin
    cyc++;
    if (ghi & glo) overlap_seen++;
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      void'(due_q.pop_front());
      chk(req_q.pop_front(), {ghi, glo}, exp_q.pop_front());
    end
  end

  function automatic logic decide(logic prev, int s, int a, int i, int b);
    int e;
    e = s - a - i;
    if (e > b)       return 1'b1;
    else if (e < -b) return 1'b0;
    else             return prev;
  endfunction

  // driver: applies one sample and queues the expected settled gates
  task automatic drive(int sa, int sb, int sc, int aa, int ab, int ac,
                       int ia, int ib, int ic, string req);
    int s[3]; int a[3]; int i[3];
    s = '{sa, sb, sc}; a = '{aa, ab, ac}; i = '{ia, ib, ic};
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      src[k] = IW'(s[k]);
      act[k] = IW'(a[k]);
      inv[k] = IW'(i[k]);
      st[k]  = decide(st[k], s[k], a[k], i[k], int'(band));
    end
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    due_q.push_back(cyc + int'(dead) + 8);
    exp_q.push_back(en ? {st, ~st} : 6'b0);
    req_q.push_back(req);
  endtask

  task automatic settle();
    repeat (int'(dead) + 12) @(negedge clk);
  endtask

  // counts cycles with both gates of leg low around a flip
  task automatic gap(int leg, int expv, string req);
    int lows = 0;
    for (int n = 0; n < 60; n++) begin
      @(negedge clk);
      if (!ghi[leg] && !glo[leg]) lows++;
      else if (lows > 0) break;
    end
    chk_int(req, lows, expv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset", {ghi, glo}, 6'b0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 no sample yet", {ghi, glo}, 6'b0);

    // first sample inside band -> lower gates
    drive(50, -50, 100, 0, 0, 0, 0, 0, 0, "R8 first lower-on");
    settle();

    // R2/R5: only phase a leaves band upward; measure R7 gap with dead=3
    fork
      drive(500, 0, 0, 0, 0, 0, 0, 0, 0, "R5 only a flips");
      gap(0, 4, "R7 gap dead=3");
    join
    settle();

    // R4: errors exactly on band edges hold
    drive(0, 100, 0, 0, 0, 0, 100, 0, 0, "R4 band edge hold");
    settle();

    // R3 on a (-101), R2 on b (+101)
    drive(-101, 101, 0, 0, 0, 0, 0, 0, 0, "R3 a lower R2 b upper");
    settle();

    // R1 with nonzero active current
    drive(-200, 0, 300, 100, 0, 250, 0, 0, -100, "R1 subtraction");
    settle();

    // R1 extremes: wrap would invert decisions
    drive(32767, 0, -32768, -32768, 0, 32767, 32767, 0, -32768, "R1 full range");
    settle();

    // R7 boundary: dead=0 gives one-cycle gap
    dead = 8'd0;
    settle();
    fork
      drive(0, -500, 0, 0, 0, 0, 0, 0, 0, "R3 b lower dead0");
      gap(1, 1, "R7 gap dead=0");
    join
    settle();

    dead = 8'd7;
    settle();
    fork
      drive(0, 0, 500, 0, 0, 0, 0, 0, 0, "R2 c upper dead7");
      gap(2, 8, "R7 gap dead=7");
    join
    settle();

    // R9: enable drop is immediate
    @(negedge clk);
    en = 1'b0;
    #1;
    chk("R9 immediate off", {ghi, glo}, 6'b0);
    drive(-500, 500, -500, 0, 0, 0, 0, 0, 0, "R9 off while disabled");
    settle();
    chk("R9 still off", {ghi, glo}, 6'b0);
    @(negedge clk);
    en = 1'b1;
    settle();
    chk("R9 resume", {ghi, glo}, {st, ~st});

    // zero band: any nonzero error switches, zero holds
    band = '0;
    settle();
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2 band zero");
    settle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 band zero hold");
    settle();

    chk_int("R6 overlap cycles", overlap_seen, 0);
    repeat (5) @(negedge clk);
    chk_int("scoreboard drained", due_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule